// File: doc/BRIEF.md
# Pixel Block Input Framing Controller

This block sits in front of a two-dimensional block transform. It takes in unsigned 8-bit pixels that arrive in bursts of 64, one 8x8 block per burst. A start strobe marks the first pixel of each block. From then on the block counts pixels and tags each one with its position, so the transform logic downstream knows which sample it is receiving.

A block that has started always runs for exactly 64 samples. A strobe seen during a block is ignored, so corrupt or misaligned data cannot break the framing. When the 64 samples are in, the block waits for a new strobe. If the strobe is held high, blocks follow each other with no idle cycles.

Each accepted pixel is moved from the unsigned range to a signed range centred on zero. It is then presented one cycle later with a valid flag and a row-major index. Idle cycles between blocks show up at the output as cycles with valid low.

Top module: `pix_block_framer`

## Requirements
- R1: After the asynchronous active-low reset, `ready_o` is 1 and `smp_valid_o` is 0. The same holds after a clock edge at which the synchronous clear is high; a strobe at that edge does not start a block.
- R2: While idle (`ready_o` = 1), a pixel with `strobe_i` low is not accepted, so `smp_valid_o` is 0 after that edge. A pixel with `strobe_i` high starts a block as sample 0.
- R3: Each accepted pixel appears after the next rising edge with `smp_valid_o` = 1. Its `smp_index_o` counts 0 to 63 within the block, where bits [5:3] are the row and bits [2:0] are the column (index = 8*row + column).
- R4: `smp_data_o` is the accepted pixel minus 128, as a two's complement 9-bit value in the range -128 to 127.
- R5: Once a block has started, exactly 64 consecutive pixels are accepted and `strobe_i` is ignored during them. After the 64th pixel, no pixel is accepted until a new strobe.
- R6: With `strobe_i` held high, a new block starts on the cycle right after the 64th pixel, so blocks run back-to-back with no invalid cycle.
- R7: `ready_o` is 0 after the edge that takes a block's sample 0 and stays 0 through sample 62. It is 1 after the edge that takes sample 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear, active high |
| strobe_i | input | 1 | Start-of-block strobe, coincident with the first pixel |
| pix_i | input | 8 | Unsigned pixel input |
| ready_o | output | 1 | High while no block is in progress |
| smp_valid_o | output | 1 | Output sample is valid |
| smp_index_o | output | 6 | Row-major position of the sample within its block |
| smp_data_o | output | 9 | Level-shifted signed sample |

## Verification
Every result is due exactly one rising edge after the input that caused it. The bench drives each pixel on a falling edge and compares valid, index, data and ready on the next falling edge, after the one register stage has updated. The asynchronous reset is the only exception: it is checked a few nanoseconds after `rst_n` falls, without waiting for a clock. The expected index, data and ready values come from the stimulus loop counters and the arithmetic pixel-minus-128. All 256 pixel codes are swept through the back-to-back run.

// File: rtl/pix_block_framer.sv
`timescale 1ns/1ps
module pix_block_framer #(
  parameter int PIX_W    = 8,
  parameter int ROW_BITS = 3,
  localparam int IDX_W   = 2 * ROW_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    strobe_i,
  input  logic [PIX_W-1:0]        pix_i,
  output logic                    ready_o,
  output logic                    smp_valid_o,
  output logic [IDX_W-1:0]        smp_index_o,
  output logic signed [PIX_W:0]   smp_data_o
);

  localparam logic [IDX_W-1:0] LAST   = IDX_W'((1 << IDX_W) - 1);
  localparam logic [PIX_W:0]   OFFSET = (PIX_W+1)'(1 << (PIX_W - 1));

  logic             busy;
  logic [IDX_W-1:0] cnt;
  logic             take;

  assign take    = busy | strobe_i;
  assign ready_o = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cnt         <= '0;
      smp_valid_o <= 1'b0;
      smp_index_o <= '0;
      smp_data_o  <= '0;
    end else if (clr) begin
      busy        <= 1'b0;
      cnt         <= '0;
      smp_valid_o <= 1'b0;
    end else begin
      smp_valid_o <= take;
      if (take) begin
        smp_index_o <= cnt;
        smp_data_o  <= $signed({1'b0, pix_i} - OFFSET);
        cnt         <= cnt + 1'b1;
        busy        <= (cnt != LAST);
      end
    end
  end

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && strobe_i && !clr) |=> (smp_valid_o && smp_index_o == '0)); // R2

  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !strobe_i) |=> !smp_valid_o); // R2

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && smp_index_o != LAST && !clr) |=>
      (smp_valid_o && smp_index_o == $past(smp_index_o) + 1'b1)); // R5

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && smp_index_o != LAST) |-> !ready_o); // R7

  AST_LAST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && smp_index_o == LAST) |-> ready_o); // R7

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ready_o && !smp_valid_o)); // R1

endmodule

// File: tb/pix_block_framer_test.sv
`timescale 1ns/1ps
module pix_block_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic strobe = 1'b0;
  logic [7:0] pix = 8'd0;
  logic ready;
  logic valid;
  logic [5:0] idx;
  logic signed [8:0] data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pix_block_framer uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .strobe_i(strobe), .pix_i(pix),
    .ready_o(ready), .smp_valid_o(valid), .smp_index_o(idx), .smp_data_o(data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic [7:0] p, input logic c,
                      input logic ev, input int ei, input logic er, input string tag);
    strobe = s; pix = p; clr = c;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " valid"}, int'(valid), int'(ev));
    if (ev) begin
      chk({tag, " R3 index"}, int'(idx), ei);
      chk({tag, " R4 data"}, int'(data), int'(p) - 128);
    end
    chk({tag, " R7 ready"}, int'(ready), int'(er));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(ready), 1);
    chk("R1 reset valid", int'(valid), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 3; k++) step(1'b0, 8'h55, 1'b0, 1'b0, 0, 1'b1, "R2 idle");

    for (int i = 0; i < 64; i++)
      step(i == 0 || i == 10 || i == 40 || i == 63, 8'(i * 4 + 1), 1'b0,
           1'b1, i, i == 63, "R5 pulsed block");
    for (int k = 0; k < 2; k++) step(1'b0, 8'h7f, 1'b0, 1'b0, 0, 1'b1, "R5 wait after 64");

    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 64; i++)
        step(1'b1, 8'(b * 64 + i), 1'b0, 1'b1, i, i == 63, "R6 held strobe");

    for (int k = 0; k < 3; k++) step(1'b0, 8'h10, 1'b0, 1'b0, 0, 1'b1, "R2 gap");

    for (int i = 0; i < 20; i++)
      step(i == 0, 8'(255 - i), 1'b0, 1'b1, i, 1'b0, "R3 before clear");
    step(1'b1, 8'h33, 1'b1, 1'b0, 0, 1'b1, "R1 clear");
    step(1'b0, 8'h44, 1'b0, 1'b0, 0, 1'b1, "R2 after clear");
    for (int i = 0; i < 64; i++)
      step(i == 0, 8'(i * 3), 1'b0, 1'b1, i, i == 63, "R3 restart");

    for (int i = 0; i < 10; i++)
      step(i == 0, 8'(i + 100), 1'b0, 1'b1, i, 1'b0, "R3 before reset");
    rst_n = 1'b0;
    #2;
    chk("R1 async ready", int'(ready), 1);
    chk("R1 async valid", int'(valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 8'h01, 1'b0, 1'b0, 0, 1'b1, "R2 after reset");
    for (int i = 0; i < 64; i++)
      step(i == 0, 8'(200 - i), 1'b0, 1'b1, i, i == 63, "R3 block after reset");
    step(1'b0, 8'h02, 1'b0, 1'b0, 0, 1'b1, "R5 end wait");

    finish_run();
  end
endmodule